// File: doc/BRIEF.md
# Selectable Arithmetic, Logic and Shift Unit

This block is a 32-bit execution unit built from three sub-units: an adder/subtractor, a bitwise logic unit and a barrel shifter. A 2-bit unit select picks the sub-unit whose value becomes the result, or turns the output off. The logic unit reads its 4-bit function code as a truth table over each pair of operand bits, so one code field covers all sixteen two-input functions. The shifter offers pass-through, logical, arithmetic and rotate modes, and a separate direction bit sets the direction.

The result and a zero flag come from one output register. Operands and controls applied before a rising clock edge show up at the ports after that edge. A datapath places the unit between its register-read stage and its write-back stage. The decode logic drives the select and function fields.

Top module: `alsu_core`

## Requirements
- R1: With unit select 00, the result is A+B modulo 2^32 when `sub_en` is 0, and A-B modulo 2^32 when `sub_en` is 1.
- R2: With unit select 01, result bit i is `logic_fn[3 - 2*A[i] - B[i]]`. So `logic_fn[3]` gives the output for A=0,B=0 and `logic_fn[0]` gives the output for A=1,B=1. This makes 0001 AND, 0011 pass A, 0101 pass B, 0110 XOR, 0111 OR and 1110 NAND.
- R3: With unit select 10 and shift type 00, the result equals A for any shift amount.
- R4: Shift type 01 is a logical shift of A by `shift_amt` with zero fill. Direction 0 shifts left and direction 1 shifts right.
- R5: Shift type 10 shifted right fills the vacated bits with copies of A[31]. Shifted left, it gives the same value as the logical left shift.
- R6: Shift type 11 rotates A by `shift_amt`: left for direction 0, right for direction 1.
- R7: With unit select 11, the result is zero whatever the other inputs are.
- R8: The zero flag is 1 exactly when the registered result is all zeros.
- R9: The result and zero flag update one clock edge after their inputs are applied. While `rst_n` is low they hold result 0 and zero flag 1.
- R10: A shift amount of 0 returns A unchanged for every shift type and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opnd_a | input | 32 | First operand, also the value that gets shifted |
| opnd_b | input | 32 | Second operand |
| unit_sel | input | 2 | 00 arithmetic, 01 logic, 10 shift, 11 off |
| sub_en | input | 1 | Subtract instead of add |
| logic_fn | input | 4 | Truth-table code for the logic unit |
| shift_type | input | 2 | 00 none, 01 logical, 10 arithmetic, 11 rotate |
| shift_dir | input | 1 | 0 left, 1 right |
| shift_amt | input | 5 | Shift or rotate distance |
| result | output | 32 | Registered selected result |
| zero | output | 1 | Registered all-zero flag for the result |

## Verification
The only internal state is the output register, so any fault shows as a wrong result or zero flag exactly one edge after the inputs are applied. A sign-fill fault, a swapped truth-table index or a rotate that drops wrapped bits changes specific result bits in that same cycle. The vectors are chosen so that each of these faults flips an observed bit. A stale or mis-reset register appears as a wrong value on the first sample after reset.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

    typedef enum logic [1:0] {
        SEL_ARITH = 2'b00,
        SEL_LOGIC = 2'b01,
        SEL_SHIFT = 2'b10,
        SEL_OFF   = 2'b11
    } unit_sel_e;

    typedef enum logic [1:0] {
        SHT_NONE  = 2'b00,
        SHT_LOGIC = 2'b01,
        SHT_ARITH = 2'b10,
        SHT_ROT   = 2'b11
    } shift_kind_e;

    localparam logic DIR_LEFT  = 1'b0;
    localparam logic DIR_RIGHT = 1'b1;

endpackage

// File: rtl/alsu_arith.sv
module alsu_arith #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             sub_en,
    output logic [WIDTH-1:0] y
);
    // Subtraction as A + ~B + 1 through a single adder.
    logic [WIDTH-1:0] b_eff;

    always_comb begin
        b_eff = sub_en ? ~b : b;
        y     = a + b_eff + {{(WIDTH-1){1'b0}}, sub_en};
    end
endmodule

// File: rtl/alsu_logic.sv
module alsu_logic #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [3:0]       fn,
    output logic [WIDTH-1:0] y
);
    // Each bit looks up the code: code bit 3 covers a=0,b=0 and bit 0 covers a=1,b=1.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign y[i] = fn[{~a[i], ~b[i]}];
    end
endmodule

// File: rtl/alsu_shift.sv
module alsu_shift
    import alsu_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int SHAMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0]   a,
    input  logic [1:0]         kind,
    input  logic               dir,
    input  logic [SHAMT_W-1:0] amt,
    output logic [WIDTH-1:0]   y
);
    localparam int DW = 2 * WIDTH;

    logic [DW-1:0]    dbl;
    logic [DW-1:0]    dbl_l;
    logic [DW-1:0]    dbl_r;
    logic [WIDTH-1:0] shl;
    logic [WIDTH-1:0] shr;
    logic [WIDTH-1:0] sar;

    always_comb begin
        dbl   = {a, a};
        dbl_l = dbl << amt;
        dbl_r = dbl >> amt;
        shl   = a << amt;
        shr   = a >> amt;
        sar   = WIDTH'($signed(a) >>> amt);
        unique case (shift_kind_e'(kind))
            SHT_NONE:  y = a;
            SHT_LOGIC: y = (dir == DIR_RIGHT) ? shr : shl;
            SHT_ARITH: y = (dir == DIR_RIGHT) ? sar : shl;
            SHT_ROT:   y = (dir == DIR_RIGHT) ? dbl_r[WIDTH-1:0] : dbl_l[DW-1:WIDTH];
            default:   y = a;
        endcase
    end
endmodule

// File: rtl/alsu_core.sv
module alsu_core
    import alsu_pkg::*;
#(
    parameter int WIDTH   = 32,
    parameter int SHAMT_W = $clog2(WIDTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH-1:0]   opnd_a,
    input  logic [WIDTH-1:0]   opnd_b,
    input  logic [1:0]         unit_sel,
    input  logic               sub_en,
    input  logic [3:0]         logic_fn,
    input  logic [1:0]         shift_type,
    input  logic               shift_dir,
    input  logic [SHAMT_W-1:0] shift_amt,
    output logic [WIDTH-1:0]   result,
    output logic               zero
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             zf;
    } out_t;

    out_t out_d, out_q;

    logic [WIDTH-1:0] arith_y;
    logic [WIDTH-1:0] logic_y;
    logic [WIDTH-1:0] shift_y;

    alsu_arith #(.WIDTH(WIDTH)) u_arith (
        .a      (opnd_a),
        .b      (opnd_b),
        .sub_en (sub_en),
        .y      (arith_y)
    );

    alsu_logic #(.WIDTH(WIDTH)) u_logic (
        .a  (opnd_a),
        .b  (opnd_b),
        .fn (logic_fn),
        .y  (logic_y)
    );

    alsu_shift #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_shift (
        .a    (opnd_a),
        .kind (shift_type),
        .dir  (shift_dir),
        .amt  (shift_amt),
        .y    (shift_y)
    );

    always_comb begin
        unique case (unit_sel_e'(unit_sel))
            SEL_ARITH: out_d.res = arith_y;
            SEL_LOGIC: out_d.res = logic_y;
            SEL_SHIFT: out_d.res = shift_y;
            default:   out_d.res = '0;
        endcase
        out_d.zf = (out_d.res == '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q.res <= '0;
            out_q.zf  <= 1'b1;
        end else begin
            out_q <= out_d;
        end
    end

    assign result = out_q.res;
    assign zero   = out_q.zf;

    // R1: a value minus itself is zero and raises the flag
    p_sub_self_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel == SEL_ARITH && sub_en && opnd_a == opnd_b) |=> (result == '0 && zero));

    // R2: truth-table code 0110 is XOR
    p_xor_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel == SEL_LOGIC && logic_fn == 4'b0110) |=> (result == ($past(opnd_a) ^ $past(opnd_b))));

    // R3: no-shift mode passes A
    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel == SEL_SHIFT && shift_type == SHT_NONE) |=> (result == $past(opnd_a)));

    // R6: a rotate keeps the number of set bits
    p_rot_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel == SEL_SHIFT && shift_type == SHT_ROT) |=> ($countones(result) == $countones($past(opnd_a))));

    // R7: the off select gives zero
    p_off_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel == SEL_OFF) |=> (result == '0 && zero));

    // R8: the flag never disagrees with the result
    p_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        zero == (result == '0));

    // R10: a zero distance returns A
    p_amt0_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_sel == SEL_SHIFT && shift_amt == '0) |=> (result == $past(opnd_a)));
endmodule

// File: tb/alsu_core_bench.sv
module alsu_core_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [1:0]  unit_sel = '0;
    logic        sub_en = 1'b0;
    logic [3:0]  logic_fn = '0;
    logic [1:0]  shift_type = '0;
    logic        shift_dir = 1'b0;
    logic [4:0]  shift_amt = '0;
    logic [31:0] result;
    logic        zero;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    alsu_core u_alsu_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .unit_sel   (unit_sel),
        .sub_en     (sub_en),
        .logic_fn   (logic_fn),
        .shift_type (shift_type),
        .shift_dir  (shift_dir),
        .shift_amt  (shift_amt),
        .result     (result),
        .zero       (zero)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic        sub;
        logic [3:0]  fn;
        logic [1:0]  st;
        logic        sd;
        logic [4:0]  amt;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{2'b00, 1'b0, 4'h0, 2'b00, 1'b0, 5'd0,  32'h0000_0010, 32'h0000_0020, 32'h0000_0030, 8'd1},
        '{2'b00, 1'b1, 4'h0, 2'b00, 1'b0, 5'd0,  32'h0000_0005, 32'h0000_0007, 32'hFFFF_FFFE, 8'd1},
        '{2'b00, 1'b0, 4'h0, 2'b00, 1'b0, 5'd0,  32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 8'd8},
        '{2'b01, 1'b0, 4'h1, 2'b00, 1'b0, 5'd0,  32'hF0F0_1234, 32'hFF00_00FF, 32'hF000_0034, 8'd2},
        '{2'b01, 1'b0, 4'h3, 2'b00, 1'b0, 5'd0,  32'h1234_5678, 32'h9ABC_DEF0, 32'h1234_5678, 8'd2},
        '{2'b01, 1'b0, 4'h5, 2'b00, 1'b0, 5'd0,  32'h1234_5678, 32'h9ABC_DEF0, 32'h9ABC_DEF0, 8'd2},
        '{2'b01, 1'b0, 4'h6, 2'b00, 1'b0, 5'd0,  32'hFFFF_0000, 32'h0F0F_0F0F, 32'hF0F0_0F0F, 8'd2},
        '{2'b01, 1'b0, 4'h7, 2'b00, 1'b0, 5'd0,  32'hF000_0000, 32'h0000_000F, 32'hF000_000F, 8'd2},
        '{2'b01, 1'b0, 4'hE, 2'b00, 1'b0, 5'd0,  32'hFFFF_0000, 32'hFF00_FF00, 32'h00FF_FFFF, 8'd2},
        '{2'b10, 1'b0, 4'h0, 2'b00, 1'b1, 5'd7,  32'hDEAD_BEEF, 32'h0,         32'hDEAD_BEEF, 8'd3},
        '{2'b10, 1'b0, 4'h0, 2'b01, 1'b0, 5'd4,  32'h8000_000F, 32'h0,         32'h0000_00F0, 8'd4},
        '{2'b10, 1'b0, 4'h0, 2'b01, 1'b1, 5'd4,  32'h8000_000F, 32'h0,         32'h0800_0000, 8'd4},
        '{2'b10, 1'b0, 4'h0, 2'b10, 1'b1, 5'd4,  32'h8000_000F, 32'h0,         32'hF800_0000, 8'd5},
        '{2'b10, 1'b0, 4'h0, 2'b10, 1'b0, 5'd4,  32'h8000_000F, 32'h0,         32'h0000_00F0, 8'd5},
        '{2'b10, 1'b0, 4'h0, 2'b11, 1'b0, 5'd4,  32'h8000_000F, 32'h0,         32'h0000_00F8, 8'd6},
        '{2'b10, 1'b0, 4'h0, 2'b11, 1'b1, 5'd4,  32'h8000_000F, 32'h0,         32'hF800_0000, 8'd6},
        '{2'b10, 1'b0, 4'h0, 2'b11, 1'b1, 5'd0,  32'h8000_000F, 32'h0,         32'h8000_000F, 8'd10},
        '{2'b10, 1'b0, 4'h0, 2'b10, 1'b1, 5'd31, 32'h8000_0000, 32'h0,         32'hFFFF_FFFF, 8'd5},
        '{2'b11, 1'b0, 4'h7, 2'b01, 1'b0, 5'd3,  32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 8'd7},
        '{2'b10, 1'b0, 4'h0, 2'b01, 1'b1, 5'd31, 32'h8000_0000, 32'h0,         32'h0000_0001, 8'd4}
    };

    task automatic check(input string tag, input logic [31:0] exp_res);
        logic exp_z;
        exp_z = (exp_res == 32'h0);
        checks++;
        if (result !== exp_res || zero !== exp_z) begin
            errors++;
            $display("FAIL %s: result=%h zero=%b expected result=%h zero=%b",
                     tag, result, zero, exp_res, exp_z);
        end
    endtask

    task automatic apply(input vec_t v);
        opnd_a     = v.a;
        opnd_b     = v.b;
        unit_sel   = v.sel;
        sub_en     = v.sub;
        logic_fn   = v.fn;
        shift_type = v.st;
        shift_dir  = v.sd;
        shift_amt  = v.amt;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        vec_t v;
        // R9: reset state, with inputs that would otherwise give a nonzero result
        opnd_a = 32'h1234_5678;
        unit_sel = 2'b01;
        logic_fn = 4'h3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R9 reset", 32'h0);
        rst_n = 1'b1;

        // R9: the new result appears after exactly one edge
        check("R9 before edge", 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R9 one edge", 32'h1234_5678);

        // Table walk: R1 R2 R3 R4 R5 R6 R7 R8 R10
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            check($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].exp);
        end

        // R2: every code, with nibble rows ab = 11,10,01,00 at bits 3..0
        for (int f = 0; f < 16; f++) begin
            logic [3:0]  rev;
            logic [31:0] e;
            rev = {f[0], f[1], f[2], f[3]};
            e = {8{rev}};
            v = '{2'b01, 1'b0, f[3:0], 2'b00, 1'b0, 5'd0, 32'hCCCC_CCCC, 32'hAAAA_AAAA, e, 8'd2};
            apply(v);
            check($sformatf("R2 code %0d", f), e);
        end

        // R1: subtracting a value from itself, then the flag clears again
        v = '{2'b00, 1'b1, 4'h0, 2'b00, 1'b0, 5'd0, 32'h7654_3210, 32'h7654_3210, 32'h0, 8'd1};
        apply(v);
        check("R1 sub self", 32'h0);
        v = '{2'b00, 1'b1, 4'h0, 2'b00, 1'b0, 5'd0, 32'h0000_0000, 32'h0000_0001, 32'hFFFF_FFFF, 8'd1};
        apply(v);
        check("R8 flag clears", 32'hFFFF_FFFF);

        // R10: zero distance for each type and direction
        for (int t = 0; t < 8; t++) begin
            v = '{2'b10, 1'b0, 4'h0, t[1:0], t[2], 5'd0, 32'hA5C3_0F96, 32'h0, 32'hA5C3_0F96, 8'd10};
            apply(v);
            check("R10 amt0", 32'hA5C3_0F96);
        end

        // R6: rotate by 31 each way
        v = '{2'b10, 1'b0, 4'h0, 2'b11, 1'b0, 5'd31, 32'h0000_0001, 32'h0, 32'h8000_0000, 8'd6};
        apply(v);
        check("R6 rotl 31", 32'h8000_0000);
        v = '{2'b10, 1'b0, 4'h0, 2'b11, 1'b1, 5'd31, 32'h0000_0001, 32'h0, 32'h0000_0002, 8'd6};
        apply(v);
        check("R6 rotr 31", 32'h0000_0002);

        // R9: reset in mid-run clears the output
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R9 mid reset", 32'h0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule